// File: doc/BRIEF.md
# Four-phase clock-domain word transfer

This block carries one 32-bit word at a time from a source clock domain to an unrelated destination clock domain. A requester in the source domain presents a word and asserts `avail_i`. The sender latches the word onto an internal bus and raises a request. The receiver captures the bus once it sees that request, answers with an acknowledge, and then drops the acknowledge when the request goes away. Only the request and acknowledge bits cross between the domains. Each bit passes through a two-flop synchronizer in the domain that reads it. The wide bus is never synchronized: the protocol holds it frozen for the whole time the receiver could sample it.

On the source side, `busy_o` tells the requester when a word will not be taken. A requester keeps `avail_i` high until `busy_o` is low, or until it has seen the word accepted. On the destination side, `word_o` holds the last captured word, and `valid_o` marks each new capture with a single-cycle pulse. Each domain has its own active-low asynchronous reset.

Top module: `hs_word_xfer`

## Requirements
- R1: While either reset is low, that domain's outputs are at rest: `busy_o`=0 in the source domain, and `valid_o`=0 with `word_o`=0 in the destination domain.
- R2: With `busy_o` low, `avail_i` high at a source rising edge accepts `word_i`, and `busy_o` is high after that edge.
- R3: Every accepted word appears unchanged on `word_o`, together with a `valid_o` pulse. Exactly one pulse occurs per accepted word.
- R4: `valid_o` is high for exactly one destination clock cycle per transfer.
- R5: `avail_i` raised while a transfer is still waiting for its acknowledge has no effect. The word offered then is never delivered unless it is still offered when the handshake completes.
- R6: The request drops only after the synchronized acknowledge has been seen. The sender's word bus does not change while the request or the synchronized acknowledge is high. `busy_o` stays high at least until the word has been delivered.
- R7: If `avail_i` is high when the acknowledge has fallen back low, the next transfer starts at once with the word then on `word_i`. `busy_o` stays high across both transfers.
- R8: `word_o` changes only at the edge that raises `valid_o`, and holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk_i | input | 1 | Source domain clock |
| src_rst_ni | input | 1 | Source domain asynchronous reset, active low |
| avail_i | input | 1 | Word on `word_i` is offered for transfer |
| word_i | input | 32 | Word to transfer |
| busy_o | output | 1 | Sender is mid-transfer and takes no new word |
| dst_clk_i | input | 1 | Destination domain clock |
| dst_rst_ni | input | 1 | Destination domain asynchronous reset, active low |
| word_o | output | 32 | Last word captured in the destination domain |
| valid_o | output | 1 | One-cycle pulse when `word_o` is updated |

## Verification
A sender stuck in its request state shows up as `busy_o` never falling. This is visible within a few tens of source cycles after the `valid_o` pulse. A receiver that misses the request's fall never drops its acknowledge, so `busy_o` hangs in the same way. A sender that reloads its bus mid-transfer, or that takes a request while busy, delivers a wrong or extra word on `word_o` within one handshake round trip. A broken capture path gives a doubled or missing `valid_o` pulse. This is seen in the destination cycle right after the capture.

// File: rtl/hs_xfer_pkg.sv
package hs_xfer_pkg;
  typedef enum logic [1:0] {
    SND_IDLE  = 2'd0,
    SND_REQ   = 2'd1,
    SND_DRAIN = 2'd2
  } snd_state_e;

  typedef enum logic {
    RCV_IDLE = 1'b0,
    RCV_ACK  = 1'b1
  } rcv_state_e;
endpackage

// File: rtl/hs_bit_sync.sv
module hs_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[LAST-1:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[LAST];
endmodule

// File: rtl/hs_sender.sv
module hs_sender
  import hs_xfer_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             avail_i,
  input  logic [WIDTH-1:0] word_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [WIDTH-1:0] bus_o,
  output logic             busy_o,
  output logic             ack_seen_o
);
  snd_state_e       state_q, state_d;
  logic [WIDTH-1:0] bus_q;
  logic             ack_s;
  logic             load;

  hs_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_i),
    .q_o   (ack_s)
  );

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    unique case (state_q)
      SND_IDLE: begin
        if (avail_i) begin
          load    = 1'b1;
          state_d = SND_REQ;
        end
      end
      SND_REQ: begin
        if (ack_s) state_d = SND_DRAIN;
      end
      SND_DRAIN: begin
        if (!ack_s) begin
          if (avail_i) begin
            load    = 1'b1;
            state_d = SND_REQ;
          end else begin
            state_d = SND_IDLE;
          end
        end
      end
      default: state_d = SND_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SND_IDLE;
      bus_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load) bus_q <= word_i;
    end
  end

  assign req_o      = (state_q == SND_REQ);
  assign busy_o     = (state_q != SND_IDLE);
  assign bus_o      = bus_q;
  assign ack_seen_o = ack_s;
endmodule

// File: rtl/hs_receiver.sv
module hs_receiver
  import hs_xfer_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [WIDTH-1:0] bus_i,
  output logic             ack_o,
  output logic [WIDTH-1:0] word_o,
  output logic             valid_o
);
  rcv_state_e       state_q, state_d;
  logic [WIDTH-1:0] word_q;
  logic             valid_q;
  logic             req_s;
  logic             capture;

  hs_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  always_comb begin
    state_d = state_q;
    capture = 1'b0;
    unique case (state_q)
      RCV_IDLE: begin
        if (req_s) begin
          capture = 1'b1;
          state_d = RCV_ACK;
        end
      end
      RCV_ACK: begin
        if (!req_s) state_d = RCV_IDLE;
      end
      default: state_d = RCV_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RCV_IDLE;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= capture;
      if (capture) word_q <= bus_i;
    end
  end

  assign ack_o   = (state_q == RCV_ACK);
  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/hs_word_xfer.sv
module hs_word_xfer #(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             src_clk_i,
  input  logic             src_rst_ni,
  input  logic             avail_i,
  input  logic [WIDTH-1:0] word_i,
  output logic             busy_o,
  input  logic             dst_clk_i,
  input  logic             dst_rst_ni,
  output logic [WIDTH-1:0] word_o,
  output logic             valid_o
);
  logic             req_w;
  logic             ack_w;
  logic             ack_seen_w;
  logic [WIDTH-1:0] bus_w;

  hs_sender #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_snd (
    .clk_i     (src_clk_i),
    .rst_ni    (src_rst_ni),
    .avail_i   (avail_i),
    .word_i    (word_i),
    .ack_i     (ack_w),
    .req_o     (req_w),
    .bus_o     (bus_w),
    .busy_o    (busy_o),
    .ack_seen_o(ack_seen_w)
  );

  hs_receiver #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_rcv (
    .clk_i  (dst_clk_i),
    .rst_ni (dst_rst_ni),
    .req_i  (req_w),
    .bus_i  (bus_w),
    .ack_o  (ack_w),
    .word_o (word_o),
    .valid_o(valid_o)
  );
endmodule

// File: rtl/hs_word_xfer_chk.sv
module hs_word_xfer_chk #(
  parameter int WIDTH = 32
) (
  input logic             src_clk_i,
  input logic             src_rst_ni,
  input logic             dst_clk_i,
  input logic             dst_rst_ni,
  input logic             avail_i,
  input logic             busy_o,
  input logic             valid_o,
  input logic [WIDTH-1:0] word_o,
  input logic             req_s,
  input logic             ack_seen,
  input logic [WIDTH-1:0] bus
);
  // R1: rest values while reset is held
  always @(posedge src_clk_i) begin
    if (!src_rst_ni) a_r1_src_rest: assert (busy_o == 1'b0);
  end
  always @(posedge dst_clk_i) begin
    if (!dst_rst_ni) a_r1_dst_rest: assert (valid_o == 1'b0 && word_o == '0);
  end

  a_r2_accept_sets_busy: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    (!busy_o && avail_i) |=> busy_o);

  a_r4_valid_one_cycle: assert property (@(posedge dst_clk_i) disable iff (!dst_rst_ni)
    valid_o |=> !valid_o);

  a_r6_req_drops_on_ack: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    $fell(req_s) |-> $past(ack_seen));

  a_r6_bus_hold_req: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    req_s |=> $stable(bus));

  a_r6_bus_hold_ack: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    ack_seen |=> $stable(bus));

  a_r8_word_holds: assert property (@(posedge dst_clk_i) disable iff (!dst_rst_ni)
    !valid_o |-> $stable(word_o));
endmodule

bind hs_word_xfer hs_word_xfer_chk #(.WIDTH(WIDTH)) u_chk (
  .src_clk_i (src_clk_i),
  .src_rst_ni(src_rst_ni),
  .dst_clk_i (dst_clk_i),
  .dst_rst_ni(dst_rst_ni),
  .avail_i   (avail_i),
  .busy_o    (busy_o),
  .valid_o   (valid_o),
  .word_o    (word_o),
  .req_s     (req_w),
  .ack_seen  (ack_seen_w),
  .bus       (bus_w)
);

// File: tb/tb_hs_word_xfer.sv
`timescale 1ns/1ps
module tb_hs_word_xfer;
  typedef struct packed {
    logic [31:0] word;
    logic        poke;
    logic [31:0] junk;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'h1234_5678, 1'b0, 32'h0000_0000},
    '{32'hFFFF_FFFF, 1'b1, 32'hDEAD_BEEF},
    '{32'h0000_0000, 1'b0, 32'h0000_0000},
    '{32'hA5A5_5A5A, 1'b1, 32'h0F0F_0F0F},
    '{32'h8000_0001, 1'b0, 32'h0000_0000},
    '{32'h7FFF_FFFE, 1'b1, 32'h1111_1111}
  };

  logic        src_clk = 1'b0;
  logic        dst_clk = 1'b0;
  logic        src_rst_n = 1'b0;
  logic        dst_rst_n = 1'b0;
  logic        avail = 1'b0;
  logic [31:0] word_in = '0;
  logic        busy;
  logic [31:0] word_out;
  logic        valid;

  int total = 0;
  int bad = 0;
  int rx_cnt = 0;
  logic [31:0] rx_log [32];
  logic prev_valid = 1'b0;

  always #10  src_clk = ~src_clk;   // 50 MHz source
  always #7.5 dst_clk = ~dst_clk;

  hs_word_xfer dut (
    .src_clk_i (src_clk),
    .src_rst_ni(src_rst_n),
    .avail_i   (avail),
    .word_i    (word_in),
    .busy_o    (busy),
    .dst_clk_i (dst_clk),
    .dst_rst_ni(dst_rst_n),
    .word_o    (word_out),
    .valid_o   (valid)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // destination monitor: log deliveries, check pulse width (R4)
  always @(negedge dst_clk) begin
    if (valid) begin
      if (rx_cnt < 32) rx_log[rx_cnt] = word_out;
      rx_cnt++;
      chk(!prev_valid, "R4 valid_o wider than one cycle", 32'(prev_valid), 32'd0);
    end
    prev_valid = valid;
  end

  task automatic xfer(input logic [31:0] w, input bit poke, input logic [31:0] junk);
    int base;
    int guard;
    bit early;
    @(negedge src_clk);
    while (busy) @(negedge src_clk);
    base = rx_cnt;
    avail = 1'b1;
    word_in = w;
    @(negedge src_clk);
    avail = 1'b0;
    chk(busy === 1'b1, "R2 busy after accept", 32'(busy), 32'd1);
    if (poke) begin
      word_in = junk;
      avail = 1'b1;
      @(negedge src_clk);
      avail = 1'b0;
    end
    guard = 0;
    early = 1'b0;
    while (rx_cnt == base && guard < 200) begin
      @(negedge src_clk);
      if (!busy && rx_cnt == base) early = 1'b1;
      guard++;
    end
    chk(!early, "R6 busy_o fell before delivery", 32'(early), 32'd0);
    chk(rx_cnt == base + 1, "R3 one delivery per word", 32'(rx_cnt - base), 32'd1);
    chk(rx_log[base] == w, "R3 delivered word", rx_log[base], w);
    guard = 0;
    while (busy && guard < 200) begin
      @(negedge src_clk);
      guard++;
    end
    if (poke) begin
      repeat (30) @(negedge dst_clk);
      chk(rx_cnt == base + 1, "R5 word offered while busy was sent", 32'(rx_cnt - base), 32'd1);
      chk(word_out == w, "R5 word_o changed by ignored offer", word_out, w);
    end
    chk(word_out == w, "R8 word_o holds after pulse", word_out, w);
  endtask

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    int guard;
    bit gap;
    repeat (3) @(negedge src_clk);
    chk(busy == 1'b0, "R1 busy_o in reset", 32'(busy), 32'd0);
    chk(valid == 1'b0, "R1 valid_o in reset", 32'(valid), 32'd0);
    chk(word_out == '0, "R1 word_o in reset", word_out, 32'd0);
    #1;
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      xfer(VECS[i].word, VECS[i].poke, VECS[i].junk);
    end

    // R7: avail_i held across completion starts the next word immediately
    @(negedge src_clk);
    while (busy) @(negedge src_clk);
    base = rx_cnt;
    avail = 1'b1;
    word_in = 32'hC0DE_0001;
    @(negedge src_clk);
    word_in = 32'hC0DE_0002;
    gap = 1'b0;
    guard = 0;
    while (rx_cnt < base + 2 && guard < 400) begin
      @(negedge src_clk);
      if (!busy) gap = 1'b1;
      guard++;
    end
    avail = 1'b0;
    chk(!gap, "R7 busy_o dropped between chained words", 32'(gap), 32'd0);
    chk(rx_log[base] == 32'hC0DE_0001, "R7 first chained word", rx_log[base], 32'hC0DE_0001);
    chk(rx_log[base+1] == 32'hC0DE_0002, "R7 second chained word", rx_log[base+1], 32'hC0DE_0002);
    guard = 0;
    while (busy && guard < 200) begin
      @(negedge src_clk);
      guard++;
    end
    repeat (30) @(negedge dst_clk);
    chk(rx_cnt == base + 2, "R7 chained transfer count", 32'(rx_cnt - base), 32'd2);

    // R1: reset again while idle
    @(negedge src_clk);
    #1;
    src_rst_n = 1'b0;
    dst_rst_n = 1'b0;
    repeat (2) @(negedge src_clk);
    chk(busy == 1'b0, "R1 busy_o after re-reset", 32'(busy), 32'd0);
    chk(word_out == '0, "R1 word_o after re-reset", word_out, 32'd0);
    chk(valid == 1'b0, "R1 valid_o after re-reset", 32'(valid), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule